// File: doc/BRIEF.md
# Function-Coded Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit of parameter width (32 bits by default). Each evaluation takes two operands and a three-bit operation code and returns one result word. A zero indication follows the result. The unit has no clock and no storage, so the result follows its inputs within the same evaluation.

The top code bit controls one shared operand path. When the bit is set, the second operand is complemented, and the same bit is fed in as the carry-in of the single adder. The add becomes a subtract, and the bitwise AND and OR become AND-NOT and OR-NOT.

The two low code bits pick one of four result sources: the AND word, the OR word, the adder sum, or the sum's most significant bit padded with zeros. When the subtract is active, that last source gives the set-less-than operation. It reports the sign of the difference and is correct as a signed comparison only while the subtraction does not overflow. No correction for overflow is made.

Code 3'b011 yields the zero-padded sign bit of the unmodified sum. That value is defined but carries no meaning.

Top module: `func_alu`

## Requirements
- R1: Code 3'b000 gives res_o = opa_i AND opb_i.
- R2: Code 3'b001 gives res_o = opa_i OR opb_i.
- R3: Code 3'b010 gives res_o = opa_i + opb_i modulo 2^W; the carry out of the top bit is dropped.
- R4: Codes 3'b100 and 3'b101 give opa_i AND (NOT opb_i) and opa_i OR (NOT opb_i) respectively.
- R5: Code 3'b110 gives res_o = opa_i + (NOT opb_i) + 1 modulo 2^W, that is, opa_i - opb_i.
- R6: Code 3'b111 gives bit 0 equal to bit W-1 of (opa_i - opb_i) and all other bits 0. For example, 25 and 32 give 1, and equal operands give 0.
- R7: zero_o is 1 exactly when every bit of res_o is 0, under every code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | W | First operand |
| opb_i | input | W | Second operand; complemented when func_i[2] is 1 |
| func_i | input | 3 | Operation code: bit 2 = invert/carry-in, bits 1:0 = result source |
| res_o | output | W | Result word |
| zero_o | output | 1 | High when res_o is all zeros |

## Verification
Two things always happen in the same evaluation: the complement of the second operand and the adder carry-in. Both are driven by func_i[2], so the operand inversion and the +1 of the subtraction act together. The bench provokes this with codes 3'b110 and 3'b111 using operands at the extremes: zero, all ones, the most negative value, and equal pairs. It then compares res_o with a model that forms the plain difference. The zero flag falls in the same evaluation as every result. The bench judges it against the model's result for each of those operand pairs, including the subtract of equal operands, which must raise it.

// File: rtl/alu_pkg.sv
package alu_pkg;

    // Operation codes; bit 2 is the invert/carry-in control, bits 1:0 pick the source.
    typedef enum logic [2:0] {
        OP_AND  = 3'b000,
        OP_OR   = 3'b001,
        OP_ADD  = 3'b010,
        OP_RSV  = 3'b011,
        OP_ANDN = 3'b100,
        OP_ORN  = 3'b101,
        OP_SUB  = 3'b110,
        OP_SLT  = 3'b111
    } alu_op_e;

    // Result source selected by the two low code bits.
    typedef enum logic [1:0] {
        SRC_AND  = 2'b00,
        SRC_OR   = 2'b01,
        SRC_SUM  = 2'b10,
        SRC_SIGN = 2'b11
    } res_src_e;

endpackage

// File: rtl/alu_operand_prep.sv
module alu_operand_prep #(
    parameter int W = 32
) (
    input  logic [W-1:0] opb_i,
    input  logic         inv_i,
    output logic [W-1:0] opb_o
);
    // Per-bit conditional inversion, shared by logic and arithmetic paths.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign opb_o[i] = opb_i[i] ^ inv_i;
    end
endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
    parameter int W      = 32,
    parameter bit RIPPLE = 1'b0
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o
);
    if (RIPPLE) begin : g_ripple
        // Explicit chain of full adders.
        logic [W:0] carry;
        assign carry[0] = cin_i;
        for (genvar i = 0; i < W; i++) begin : g_fa
            assign sum_o[i]   = a_i[i] ^ b_i[i] ^ carry[i];
            assign carry[i+1] = (a_i[i] & b_i[i]) | (carry[i] & (a_i[i] | b_i[i]));
        end
    end else begin : g_infer
        // Leave the carry structure to the implementation tools.
        logic [W:0] wide;
        assign wide  = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
        assign sum_o = wide[W-1:0];
    end
endmodule

// File: rtl/alu_out_mux.sv
module alu_out_mux
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] and_i,
    input  logic [W-1:0] or_i,
    input  logic [W-1:0] sum_i,
    input  res_src_e     src_i,
    output logic [W-1:0] res_o
);
    always_comb begin
        unique case (src_i)
            SRC_AND:  res_o = and_i;
            SRC_OR:   res_o = or_i;
            SRC_SUM:  res_o = sum_i;
            SRC_SIGN: res_o = {{(W-1){1'b0}}, sum_i[W-1]};
            default:  res_o = '0;
        endcase
    end
endmodule

// File: rtl/func_alu.sv
module func_alu
    import alu_pkg::*;
#(
    parameter int W        = 32,
    parameter bit RIPPLE   = 1'b0,
    parameter bit HAS_ZERO = 1'b1
) (
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    input  logic [2:0]   func_i,
    output logic [W-1:0] res_o,
    output logic         zero_o
);
    logic         inv;
    res_src_e     src;
    logic [W-1:0] opb_eff;
    logic [W-1:0] sum;
    logic [W-1:0] and_w;
    logic [W-1:0] or_w;

    assign inv = func_i[2];
    assign src = res_src_e'(func_i[1:0]);

    alu_operand_prep #(.W(W)) prep_i (
        .opb_i (opb_i),
        .inv_i (inv),
        .opb_o (opb_eff)
    );

    assign and_w = opa_i & opb_eff;
    assign or_w  = opa_i | opb_eff;

    alu_adder #(.W(W), .RIPPLE(RIPPLE)) add_i (
        .a_i   (opa_i),
        .b_i   (opb_eff),
        .cin_i (inv),
        .sum_o (sum)
    );

    alu_out_mux #(.W(W)) mux_i (
        .and_i (and_w),
        .or_i  (or_w),
        .sum_i (sum),
        .src_i (src),
        .res_o (res_o)
    );

    if (HAS_ZERO) begin : g_zero
        assign zero_o = ~|res_o;
    end else begin : g_nozero
        assign zero_o = 1'b0;
    end
endmodule

// File: rtl/func_alu_chk.sv
module func_alu_chk
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input logic [W-1:0] opa_i,
    input logic [W-1:0] opb_i,
    input logic [2:0]   func_i,
    input logic [W-1:0] res_o,
    input logic         zero_o
);
    logic [W-1:0] diff;
    assign diff = opa_i - opb_i;

    always_comb begin
        if (func_i == OP_AND)
            a_r1_and: assert (res_o == (opa_i & opb_i));
        if (func_i == OP_OR)
            a_r2_or: assert (res_o == (opa_i | opb_i));
        if (func_i == OP_ADD)
            a_r3_add: assert (res_o == opa_i + opb_i);
        if (func_i == OP_ANDN)
            a_r4_andn: assert ((res_o & opb_i) == '0);
        if (func_i == OP_ORN)
            a_r4_orn: assert ((res_o | opb_i) == '1);
        if (func_i == OP_SUB)
            a_r5_sub: assert (res_o + opb_i == opa_i);
        if (func_i == OP_SLT)
            a_r6_slt: assert ($countones(res_o[W-1:1]) == 0 && res_o[0] == diff[W-1]);
        a_r7_zero: assert (zero_o == ($countones(res_o) == 0));
    end
endmodule

bind func_alu func_alu_chk #(.W(W)) chk_i (
    .opa_i  (opa_i),
    .opb_i  (opb_i),
    .func_i (func_i),
    .res_o  (res_o),
    .zero_o (zero_o)
);

// File: tb/func_alu_tb_top.sv
module func_alu_tb_top;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic [W-1:0] opa, opb;
    logic [2:0]   func;
    logic [W-1:0] res;
    logic         zero;
    int           checks = 0;
    int           errors = 0;
    bit           done   = 1'b0;

    always #5 clk = ~clk;

    func_alu #(.W(W)) dut_i (
        .opa_i  (opa),
        .opb_i  (opb),
        .func_i (func),
        .res_o  (res),
        .zero_o (zero)
    );

    // {code, a, b, expected}
    localparam int NV = 14;
    localparam logic [3+3*W-1:0] VEC [0:NV-1] = '{
        {3'b000, 32'hF0F0_1234, 32'hFF00_00FF, 32'hF000_0034},
        {3'b001, 32'h0F00_0001, 32'h00F0_0010, 32'h0FF0_0011},
        {3'b010, 32'd25,        32'd32,        32'd57},
        {3'b010, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000},
        {3'b100, 32'hFFFF_0000, 32'hFF00_FF00, 32'h00FF_0000},
        {3'b101, 32'h0000_0001, 32'hFFFF_FFF0, 32'h0000_000F},
        {3'b110, 32'd25,        32'd32,        32'hFFFF_FFF9},
        {3'b110, 32'd7,         32'd7,         32'h0000_0000},
        {3'b110, 32'h0000_0000, 32'h8000_0000, 32'h8000_0000},
        {3'b111, 32'd25,        32'd32,        32'h0000_0001},
        {3'b111, 32'd32,        32'd25,        32'h0000_0000},
        {3'b111, 32'h1234_5678, 32'h1234_5678, 32'h0000_0000},
        {3'b111, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0001},
        {3'b111, 32'h8000_0000, 32'h0000_0001, 32'h0000_0000}
    };

    function automatic logic [W-1:0] model(input logic [2:0] f, input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] d;
        d = a - b;
        case (f)
            3'b000:  return a & b;      // R1
            3'b001:  return a | b;      // R2
            3'b010:  return a + b;      // R3
            3'b100:  return a & ~b;     // R4
            3'b101:  return a | ~b;     // R4
            3'b110:  return d;          // R5
            3'b111:  return {{(W-1){1'b0}}, d[W-1]}; // R6
            default: return '0;
        endcase
    endfunction

    function automatic string tag(input logic [2:0] f);
        case (f)
            3'b000: return "R1";
            3'b001: return "R2";
            3'b010: return "R3";
            3'b100, 3'b101: return "R4";
            3'b110: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic apply(input logic [2:0] f, input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] exp);
        @(negedge clk);
        func = f; opa = a; opb = b;
        #1;
        checks++;
        if (res !== exp) begin
            errors++;
            $display("FAIL %s code=%b a=%h b=%h res=%h expected=%h", tag(f), f, a, b, res, exp);
        end
        checks++;
        if (zero !== (exp == '0)) begin
            errors++;
            $display("FAIL R7 code=%b a=%h b=%h zero=%b expected=%b", f, a, b, zero, (exp == '0));
        end
    endtask

    initial begin
        logic [W-1:0] corner [0:4];
        corner[0] = '0;
        corner[1] = '1;
        corner[2] = 32'h8000_0000;
        corner[3] = 32'h7FFF_FFFF;
        corner[4] = 32'h0000_0001;
        func = 3'b000; opa = '0; opb = '0;
        #1;
        // Idle state: AND of zeros gives zero and raises the flag (R1, R7).
        checks++;
        if (res !== '0 || zero !== 1'b1) begin
            errors++;
            $display("FAIL R7 idle res=%h zero=%b expected=00000000 1", res, zero);
        end
        for (int i = 0; i < NV; i++) begin
            logic [3+3*W-1:0] v;
            v = VEC[i];
            apply(v[3*W+2 -: 3], v[3*W-1 -: W], v[2*W-1 -: W], v[W-1:0]);
        end
        for (int f = 0; f < 8; f++) begin
            if (f == 3) continue;
            for (int i = 0; i < 5; i++) begin
                for (int j = 0; j < 5; j++) begin
                    apply(3'(f), corner[i], corner[j], model(3'(f), corner[i], corner[j]));
                end
            end
            for (int k = 0; k < 40; k++) begin
                logic [W-1:0] a, b;
                a = $urandom;
                b = (k % 8 == 0) ? a : $urandom;
                apply(3'(f), a, b, model(3'(f), a, b));
            end
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule